// File: doc/BRIEF.md
# Free-Running Timer with Compare-Clear

This block is a 16-bit up-counter that advances on a tick taken from a programmable power-of-two divider of the system clock. The counter can run through its full range and wrap from 0xFFFF to 0x0000. It can also wrap early: when compare-clear mode is on, it returns to zero on the tick where it equals a programmed 16-bit compare value. Each of the two wrap events sets its own sticky flag. A single interrupt line is asserted while either flag is set and its enable bit is on.

Software controls the block over a small synchronous register bus with three word addresses: control/status, compare value and counter value. The counter comes out of reset stopped. The compare value has no reset value, so software must load it before it starts the counter. A stop bit freezes the count, and a self-clearing clear bit zeroes it.

Top module: `ftmr_top`

## Requirements
- R1: After reset the counter reads 0, the interrupt is low, and the control/status word reads 0x0020: stop bit 5 is set and every other field, including both flags and both enables, is 0.
- R2: Control bits [2:0] select a divide of 2^n. Any write to the low byte of control/status restarts the divider. When the counter is running and was zeroed by that write, it reads floor(M / 2^n) after M further clock edges.
- R3: With mode bit 4 at 0, the counter wraps from 0xFFFF to 0x0000 and sets the overflow flag at bit 7 on that step. The compare-clear flag is unaffected.
- R4: With mode bit 4 at 1, a tick on which the counter equals the compare value loads 0x0000 and sets the compare-clear flag at bit 9. The counter therefore cycles through compare value + 1 states.
- R5: While stop bit 5 is 1, the counter holds its value.
- R6: Writing 1 to clear bit 3 loads the counter with 0x0000 at the edge that takes the write. Bit 3 always reads back 0.
- R7: Flag bits 7 and 9 are sticky. Writing 0 to a flag's bit clears it and writing 1 has no effect. If a new event falls on the same edge as the clearing write, the flag stays set.
- R8: The interrupt output equals (overflow flag AND overflow enable bit 6) OR (compare-clear flag AND compare-clear enable bit 8). It changes at the same edge as the flags.
- R9: The compare register at address 1 changes only on a write with both byte enables set. Writes with only one byte enable leave it unchanged.
- R10: A read returns data on bus_rdata one cycle after the read strobe. Address 0 returns control/status, address 1 returns the compare value and address 2 returns the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address (0 control/status, 1 compare, 2 counter) |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that bus strobes are clean, single-cycle and synchronous to the clock. They also assume that the compare value has been written before compare-clear mode runs, because an unwritten compare register makes the match time undefined. The stimulus loads the compare register before it enables mode 1. It drives every bus access between clock edges and holds each access for exactly one edge. This lets the expected counter values be derived by counting edges from the write that restarted the divider.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam int FT_SEL_W = 3;
  // control/status field positions; lane 0 holds bits 7:0, lane 1 bits 15:8
  localparam int FT_B_CLR  = 3;
  localparam int FT_B_MODE = 4;
  localparam int FT_B_STOP = 5;
  localparam int FT_B_OVIE = 6;
  localparam int FT_B_OVF  = 7;
  localparam int FT_B_CMIE = 8;
  localparam int FT_B_CMF  = 9;
  // word addresses
  localparam int FT_A_CTRL = 0;
  localparam int FT_A_CMP  = 1;
  localparam int FT_A_CNT  = 2;

  typedef struct packed {
    logic ovf;
    logic match;
  } ftmr_evt_t;
endpackage

// File: rtl/ftmr_prescaler.sv
module ftmr_prescaler #(
  parameter int SEL_W = ftmr_pkg::FT_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  genvar g;
  generate
    for (g = 0; g < PRE_W; g++) begin : g_mask
      assign mask[g] = (int'(sel) > g);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  assign tick = ((pre_q & mask) == mask);
endmodule

// File: rtl/ftmr_counter.sv
module ftmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 run,
  input  logic                 mode,
  input  logic                 clr,
  input  logic [CNT_W-1:0]     cmp,
  output logic [CNT_W-1:0]     cnt,
  output ftmr_pkg::ftmr_evt_t  evt
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n     = cnt_q;
    evt.ovf   = 1'b0;
    evt.match = 1'b0;
    if (clr) begin
      cnt_n = '0;
    end else if (tick && run) begin
      if (mode && (cnt_q == cmp)) begin
        cnt_n     = '0;
        evt.match = 1'b1;
      end else begin
        cnt_n   = cnt_q + 1'b1;
        evt.ovf = (cnt_q == '1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ftmr_regs.sv
module ftmr_regs #(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = ftmr_pkg::FT_SEL_W,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W/8-1:0]  bus_be,
  input  logic [CNT_W-1:0]    bus_wdata,
  input  logic [CNT_W-1:0]    cnt,
  input  ftmr_pkg::ftmr_evt_t evt,
  output logic [SEL_W-1:0]    sel_o,
  output logic                stop_o,
  output logic                mode_o,
  output logic                clr_o,
  output logic                restart_o,
  output logic [CNT_W-1:0]    cmp_o,
  output logic                ovf_flag_o,
  output logic                cmp_flag_o,
  output logic                ovf_ie_o,
  output logic                cmp_ie_o,
  output logic                irq_o,
  output logic [CNT_W-1:0]    rdata_o
);
  import ftmr_pkg::*;
  localparam int BE_W = CNT_W / 8;

  logic             wr_ctrl, wr_cmp, rd, lo_wr, hi_wr;
  logic [SEL_W-1:0] sel_q;
  logic             stop_q, mode_q, ovf_ie_q, cmp_ie_q, ovf_q, cmf_q, irq_q;
  logic             ovf_n, cmf_n, ovf_ie_n, cmp_ie_n;
  logic [CNT_W-1:0] cmp_q, rdata_q, ctrl_rd, rd_mux;

  assign wr_ctrl = bus_en && bus_we && (bus_addr == ADDR_W'(FT_A_CTRL));
  assign wr_cmp  = bus_en && bus_we && (bus_addr == ADDR_W'(FT_A_CMP)) && (&bus_be);
  assign rd      = bus_en && !bus_we;
  assign lo_wr   = wr_ctrl && bus_be[0];
  assign hi_wr   = wr_ctrl && bus_be[BE_W-1];

  assign clr_o     = lo_wr && bus_wdata[FT_B_CLR];
  assign restart_o = lo_wr;

  // event wins over a clearing write on the same edge
  always_comb begin
    ovf_n    = evt.ovf   || (ovf_q && !(lo_wr && !bus_wdata[FT_B_OVF]));
    cmf_n    = evt.match || (cmf_q && !(hi_wr && !bus_wdata[FT_B_CMF]));
    ovf_ie_n = lo_wr ? bus_wdata[FT_B_OVIE] : ovf_ie_q;
    cmp_ie_n = hi_wr ? bus_wdata[FT_B_CMIE] : cmp_ie_q;
  end

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[SEL_W-1:0]   = sel_q;
    ctrl_rd[FT_B_MODE]   = mode_q;
    ctrl_rd[FT_B_STOP]   = stop_q;
    ctrl_rd[FT_B_OVIE]   = ovf_ie_q;
    ctrl_rd[FT_B_OVF]    = ovf_q;
    ctrl_rd[FT_B_CMIE]   = cmp_ie_q;
    ctrl_rd[FT_B_CMF]    = cmf_q;
    if (bus_addr == ADDR_W'(FT_A_CMP))      rd_mux = cmp_q;
    else if (bus_addr == ADDR_W'(FT_A_CNT)) rd_mux = cnt;
    else if (bus_addr == ADDR_W'(FT_A_CTRL)) rd_mux = ctrl_rd;
    else                                    rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      stop_q   <= 1'b1;
      mode_q   <= 1'b0;
      ovf_ie_q <= 1'b0;
      cmp_ie_q <= 1'b0;
      ovf_q    <= 1'b0;
      cmf_q    <= 1'b0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (lo_wr) begin
        sel_q  <= bus_wdata[SEL_W-1:0];
        mode_q <= bus_wdata[FT_B_MODE];
        stop_q <= bus_wdata[FT_B_STOP];
      end
      ovf_ie_q <= ovf_ie_n;
      cmp_ie_q <= cmp_ie_n;
      ovf_q    <= ovf_n;
      cmf_q    <= cmf_n;
      irq_q    <= (ovf_n && ovf_ie_n) || (cmf_n && cmp_ie_n);
      if (rd) rdata_q <= rd_mux;
    end
  end

  // compare value has no reset: software loads it before use
  always_ff @(posedge clk) begin
    if (wr_cmp) cmp_q <= bus_wdata;
  end

  assign sel_o      = sel_q;
  assign stop_o     = stop_q;
  assign mode_o     = mode_q;
  assign cmp_o      = cmp_q;
  assign ovf_flag_o = ovf_q;
  assign cmp_flag_o = cmf_q;
  assign ovf_ie_o   = ovf_ie_q;
  assign cmp_ie_o   = cmp_ie_q;
  assign irq_o      = irq_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top #(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = ftmr_pkg::FT_SEL_W,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CNT_W/8-1:0] bus_be,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  output logic               irq
);
  logic [SEL_W-1:0]    sel_w;
  logic                stop_w, mode_w, clr_w, restart_w, tick_w;
  logic                ovf_flag_w, cmp_flag_w, ovf_ie_w, cmp_ie_w;
  logic [CNT_W-1:0]    cnt_w, cmp_w;
  ftmr_pkg::ftmr_evt_t evt_w;

  ftmr_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart_w), .sel(sel_w), .tick(tick_w)
  );

  ftmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_w), .run(!stop_w), .mode(mode_w),
    .clr(clr_w), .cmp(cmp_w), .cnt(cnt_w), .evt(evt_w)
  );

  ftmr_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .cnt(cnt_w), .evt(evt_w), .sel_o(sel_w), .stop_o(stop_w),
    .mode_o(mode_w), .clr_o(clr_w), .restart_o(restart_w), .cmp_o(cmp_w),
    .ovf_flag_o(ovf_flag_w), .cmp_flag_o(cmp_flag_w),
    .ovf_ie_o(ovf_ie_w), .cmp_ie_o(cmp_ie_w), .irq_o(irq),
    .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/ftmr_chk.sv
module ftmr_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              be_lo,
  input logic              be_hi,
  input logic              be_all,
  input logic              wd_clr,
  input logic              wd_ovf,
  input logic              wd_cmf,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              tick,
  input logic              stop,
  input logic              mode,
  input logic              ovf_flag,
  input logic              cmp_flag,
  input logic              ovf_ie,
  input logic              cmp_ie,
  input logic              irq
);
  logic wr_ctrl, clr_req, adv;
  assign wr_ctrl = bus_en && bus_we && (bus_addr == ADDR_W'(0));
  assign clr_req = wr_ctrl && be_lo && wd_clr;
  assign adv     = tick && !stop && !clr_req;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !irq && stop && !ovf_flag && !cmp_flag));

  p_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == '1 && !(mode && cmp == cnt)) |=> (ovf_flag && cnt == '0));

  p_cmp_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && mode && cnt == cmp) |=> (cnt == '0 && cmp_flag));

  p_stop_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (stop && !clr_req) |=> $stable(cnt));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (cnt == '0));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(wr_ctrl && be_lo && !wd_ovf)) |=> ovf_flag);

  p_cmf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !(wr_ctrl && be_hi && !wd_cmf)) |=> cmp_flag);

  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq == ((ovf_flag && ovf_ie) || (cmp_flag && cmp_ie)));

  p_cmp_bytewr_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(1) && !be_all) |=> $stable(cmp));
endmodule

bind ftmr_top ftmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .be_lo(bus_be[0]), .be_hi(bus_be[CNT_W/8-1]),
  .be_all(&bus_be), .wd_clr(bus_wdata[ftmr_pkg::FT_B_CLR]),
  .wd_ovf(bus_wdata[ftmr_pkg::FT_B_OVF]), .wd_cmf(bus_wdata[ftmr_pkg::FT_B_CMF]),
  .cnt(cnt_w), .cmp(cmp_w), .tick(tick_w), .stop(stop_w), .mode(mode_w),
  .ovf_flag(ovf_flag_w), .cmp_flag(cmp_flag_w), .ovf_ie(ovf_ie_w),
  .cmp_ie(cmp_ie_w), .irq(irq)
);

// File: tb/tb_ftmr_top.sv
module tb_ftmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0, bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] rv, first;

  always #10 clk = ~clk;

  ftmr_top dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // {sel, idle edges, expected count}
  localparam logic [34:0] VEC [0:7] = '{
    {3'd0, 16'd10,  16'd10},
    {3'd1, 16'd10,  16'd5},
    {3'd1, 16'd11,  16'd5},
    {3'd2, 16'd13,  16'd3},
    {3'd3, 16'd20,  16'd2},
    {3'd5, 16'd31,  16'd0},
    {3'd5, 16'd32,  16'd1},
    {3'd7, 16'd300, 16'd2}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd(2'd0, rv); check("R1 ctrl", rv, 16'h0020);
    rd(2'd2, rv); check("R1 cnt", rv, 16'h0000);

    // R9 / R10 compare register
    wr(2'd1, 16'h1234, 2'b11);
    rd(2'd1, rv); check("R10 cmp read", rv, 16'h1234);
    wr(2'd1, 16'h00FF, 2'b01);
    rd(2'd1, rv); check("R9 low byte ignored", rv, 16'h1234);
    wr(2'd1, 16'hFF00, 2'b10);
    rd(2'd1, rv); check("R9 high byte ignored", rv, 16'h1234);

    // R2 prescaler table
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 16'h0008 | {13'd0, VEC[i][34:32]}, 2'b11);
      idle(int'(VEC[i][31:16]));
      rd(2'd2, rv);
      check($sformatf("R2 vector %0d", i), rv, VEC[i][15:0]);
    end

    // R6 clear
    wr(2'd0, 16'h0000, 2'b11);
    idle(5);
    wr(2'd0, 16'h0008, 2'b11);
    rd(2'd2, rv); check("R6 cnt zero", rv, 16'h0000);
    rd(2'd0, rv); check("R6 clr reads 0", rv, 16'h0000);

    // R5 stop
    wr(2'd0, 16'h0020, 2'b11);
    rd(2'd2, first);
    idle(20);
    rd(2'd2, rv); check("R5 held", rv, first);

    // R3 overflow, R8 irq
    wr(2'd0, 16'h0048, 2'b11);
    idle(65534);
    rd(2'd2, rv); check("R3 pre-wrap cnt", rv, 16'hFFFE);
    check("R8 irq before wrap", {15'd0, irq}, 16'h0000);
    rd(2'd0, rv); check("R3 no flag yet", rv, 16'h0040);
    rd(2'd0, rv); check("R3 ovf flag", rv, 16'h00C0);
    check("R8 irq on ovf", {15'd0, irq}, 16'h0001);

    // R7 write 1 no effect, write 0 clears
    wr(2'd0, 16'h00C0, 2'b01);
    rd(2'd0, rv); check("R7 write1 keeps", rv, 16'h00C0);
    wr(2'd0, 16'h0040, 2'b01);
    rd(2'd0, rv); check("R7 write0 clears", rv, 16'h0040);
    check("R8 irq dropped", {15'd0, irq}, 16'h0000);

    // R4 compare-clear
    wr(2'd0, 16'h0020, 2'b11);
    wr(2'd1, 16'h0004, 2'b11);
    wr(2'd0, 16'h0118, 2'b11);          // E0
    idle(4);                            // E1..E4
    rd(2'd2, rv); check("R4 reaches cmp", rv, 16'h0004);   // E5
    rd(2'd0, rv); check("R4 flag set", rv, 16'h0310);      // E6
    check("R8 irq on match", {15'd0, irq}, 16'h0001);
    rd(2'd2, rv); check("R4 restarted", rv, 16'h0001);     // E7

    // R7 event beats clearing write on same edge (E10)
    idle(2);
    wr(2'd0, 16'h0100, 2'b10);          // E10
    rd(2'd0, rv); check("R7 event wins", rv, 16'h0310);    // E11
    wr(2'd0, 16'h0100, 2'b10);          // E12
    rd(2'd0, rv); check("R7 cleared", rv, 16'h0110);       // E13
    check("R8 irq low after clear", {15'd0, irq}, 16'h0000);

    // R8 flag without enable
    wr(2'd0, 16'h0000, 2'b10);          // E14
    idle(1);                            // E15 match
    rd(2'd0, rv); check("R8 flag no enable", rv, 16'h0210);
    check("R8 irq masked", {15'd0, irq}, 16'h0000);

    finish_run();
  end
endmodule